// File: doc/BRIEF.md
# Multi-Lane Code Group Synchronizer

This block is the receive-side link-layer controller for a multi-lane serial converter link that uses 8b/10b coding. Each lane delivers one decoded octet per character clock, with a control-character flag and a decode-error flag. The block watches every lane for a run of comma characters (K28.5, octet 0xBC with the control flag set). It drives the shared active-low SYNC request toward the transmitter. It releases that request only when every enabled lane has locked.

After release, the block waits on each lane for the comma stream to end with K28.0 (octet 0x1C with the control flag), which marks the start of the lane alignment sequence. It emits one pulse when every enabled lane has shown that character. Several events restart the link: a bad exit from the comma stream, a lane that drops sync, or a misalignment flag from downstream logic. A restart pulls SYNC low again and forces every lane back to its idle search state in the same cycle.

Top module: `cgs_sync_top`

## Requirements
- R1: During and directly after reset, `sync_n_o` is 0, `lane_synced_o` is all zero, `all_synced_o` follows only the mask and `ilas_start_o` is 0.
- R2: A lane reports synced (`lane_synced_o` bit 1) in the cycle after it has received CGS_MIN consecutive error-free comma characters (rx_is_k=1, octet 0xBC, no decode error), and not earlier.
- R3: While a lane is counting commas, any character that is not an error-free comma returns its count to zero, so a new run of CGS_MIN commas is needed.
- R4: A synced lane drops its synced bit in the cycle after a character that makes ERR_THRESH decode errors among its last ERR_WIN characters. Fewer errors in every such window leave it synced.
- R5: `sync_n_o` goes high only in the cycle after one in which every enabled lane reported synced.
- R6: After each assertion of the request, `sync_n_o` stays low for at least FRAME_LEN+1 cycles.
- R7: Once SYNC is high, an enabled lane that reports not synced drives `sync_n_o` low on the next cycle.
- R8: While SYNC is high and a lane has not yet shown the alignment start, any character on that enabled lane other than an error-free comma or an error-free K28.0 (rx_is_k=1, octet 0x1C) drives `sync_n_o` low on the next cycle.
- R9: `ilas_start_o` is a single-cycle pulse, raised in the cycle after every enabled lane has shown its first K28.0. The lanes may show it in different cycles.
- R10: `misalign_i` high while SYNC is high drives `sync_n_o` low on the next cycle.
- R11: Every restart clears all lane synced bits in the same cycle that `sync_n_o` falls.
- R12: Lanes with a 0 in `lane_en_i` are ignored by the release condition, the transition check and the loss check.
- R13: When a restart condition and the final K28.0 fall in the same cycle, the restart wins and no `ilas_start_o` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_en_i | input | NUM_LANES | Mask of active lanes |
| rx_octet_i | input | 8*NUM_LANES | Decoded octet per lane, lane 0 in bits 7:0 |
| rx_is_k_i | input | NUM_LANES | Control-character flag per lane |
| rx_dec_err_i | input | NUM_LANES | 8b/10b decode error per lane |
| misalign_i | input | 1 | Misalignment detected downstream |
| sync_n_o | output | 1 | Active-low synchronization request |
| lane_synced_o | output | NUM_LANES | Per-lane code group sync status |
| all_synced_o | output | 1 | Every enabled lane synced |
| ilas_start_o | output | 1 | Alignment sequence start pulse |

## Verification
Two events can fall in the same clock: a lane shows the final K28.0 that completes the alignment start, and a restart is requested, either by misalignment or by a bad character on another lane. The bench sets up skewed alignment starts so that the last lane's K28.0 and a misalignment flag arrive together. It expects SYNC to fall with no pulse. A cycle-accurate behavioural model, built from the requirements, is compared against every output on every clock. Directed checks at known points cover each requirement.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
    localparam logic [7:0] COMMA_OCTET  = 8'hBC;
    localparam logic [7:0] ALIGN_OCTET  = 8'h1C;

    typedef enum logic [1:0] {
        LN_INIT  = 2'd0,
        LN_CHECK = 2'd1,
        LN_DATA  = 2'd2
    } lane_state_e;

    typedef enum logic [1:0] {
        LK_REQ  = 2'd0,
        LK_WAIT = 2'd1,
        LK_DATA = 2'd2
    } link_state_e;
endpackage

// File: rtl/cgs_lane_fsm.sv
module cgs_lane_fsm
    import cgs_pkg::*;
#(
    parameter int CGS_MIN    = 4,
    parameter int ERR_WIN    = 4,
    parameter int ERR_THRESH = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] octet_i,
    input  logic       is_k_i,
    input  logic       dec_err_i,
    input  logic       restart_i,
    output logic       comma_o,
    output logic       align_k_o,
    output logic       synced_o
);
    localparam int CW = $clog2(CGS_MIN + 1);
    localparam int HW = ERR_WIN - 1;

    typedef struct packed {
        lane_state_e   st;
        logic [CW-1:0] cnt;
        logic [HW-1:0] hist;
    } lane_t;

    lane_t          q, d;
    logic           comma, align_k;
    logic [HW:0]    shifted;
    int             hits;

    always_comb begin
        comma   = is_k_i && (octet_i == COMMA_OCTET) && !dec_err_i;
        align_k = is_k_i && (octet_i == ALIGN_OCTET) && !dec_err_i;
        shifted = {q.hist, dec_err_i};
        hits    = $countones(shifted);
        d       = q;
        case (q.st)
            LN_INIT: begin
                if (comma) begin
                    d.st  = LN_CHECK;
                    d.cnt = CW'(1);
                end
            end
            LN_CHECK: begin
                if (!comma) begin
                    d.st  = LN_INIT;
                    d.cnt = '0;
                end else if (q.cnt == CW'(CGS_MIN - 1)) begin
                    d.st   = LN_DATA;
                    d.cnt  = '0;
                    d.hist = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            LN_DATA: begin
                if (hits >= ERR_THRESH) begin
                    d.st   = LN_INIT;
                    d.hist = '0;
                end else begin
                    d.hist = shifted[HW-1:0];
                end
            end
            default: d = '0;
        endcase
        if (restart_i) begin
            d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign comma_o   = comma;
    assign align_k_o = align_k;
    assign synced_o  = (q.st == LN_DATA);

    // R2: entry to DATA only straight after the last comma of a full run
    p_cgs_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LN_DATA && $past(q.st) != LN_DATA) |->
        ($past(q.st) == LN_CHECK && $past(q.cnt) == CW'(CGS_MIN - 1) && $past(comma)));

    // R3: a non-comma while counting aborts the run
    p_check_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LN_CHECK && !comma) |=> (q.st == LN_INIT));

    // R4: error threshold reached in the window drops sync
    p_err_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LN_DATA && dec_err_i && ($countones(q.hist) >= ERR_THRESH - 1)) |=>
        (q.st == LN_INIT));

    // R11: restart forces the lane back to its search state
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (q.st == LN_INIT));
endmodule

// File: rtl/cgs_link_ctrl.sv
module cgs_link_ctrl
    import cgs_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int FRAME_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_en_i,
    input  logic [NUM_LANES-1:0] lane_synced_i,
    input  logic [NUM_LANES-1:0] lane_comma_i,
    input  logic [NUM_LANES-1:0] lane_align_k_i,
    input  logic                 misalign_i,
    output logic                 restart_o,
    output logic                 sync_n_o,
    output logic                 all_synced_o,
    output logic                 ilas_start_o
);
    localparam int HOLD_W = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        link_state_e          st;
        logic [HOLD_W-1:0]    hold;
        logic [NUM_LANES-1:0] seen;
        logic                 ilas;
    } ctl_t;

    ctl_t                 q, d;
    logic                 all_ok, lost, bad_tr, restart;
    logic [NUM_LANES-1:0] pending, seen_new;

    always_comb begin
        all_ok   = &(lane_synced_i | ~lane_en_i);
        lost     = |(lane_en_i & ~lane_synced_i);
        pending  = lane_en_i & ~q.seen;
        bad_tr   = |(pending & ~lane_comma_i & ~lane_align_k_i);
        seen_new = q.seen | (pending & lane_align_k_i);
        restart  = 1'b0;
        d        = q;
        d.ilas   = 1'b0;
        case (q.st)
            LK_REQ: begin
                if (q.hold != HOLD_W'(FRAME_LEN)) d.hold = q.hold + HOLD_W'(1);
                if (q.hold == HOLD_W'(FRAME_LEN) && all_ok) begin
                    d.st   = LK_WAIT;
                    d.hold = '0;
                end
            end
            LK_WAIT: begin
                restart = lost || misalign_i || bad_tr;
                d.seen  = seen_new;
                if (&(seen_new | ~lane_en_i)) begin
                    d.st   = LK_DATA;
                    d.ilas = 1'b1;
                end
            end
            LK_DATA: begin
                restart = lost || misalign_i;
            end
            default: restart = 1'b1;
        endcase
        if (restart) begin
            d.st   = LK_REQ;
            d.hold = '0;
            d.seen = '0;
            d.ilas = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign restart_o    = restart;
    assign sync_n_o     = (q.st != LK_REQ);
    assign all_synced_o = all_ok;
    assign ilas_start_o = q.ilas;

    // R5: release only after all enabled lanes reported sync
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n_o) |-> $past(all_ok));

    // R6: minimum low time of the request
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n_o) |-> ($past(q.hold) == HOLD_W'(FRAME_LEN)));

    // R7: lost lane after release re-requests sync
    p_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n_o && |(lane_en_i & ~lane_synced_i)) |=> !sync_n_o);

    // R8: bad exit from the comma stream re-requests sync
    p_bad_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LK_WAIT && |(lane_en_i & ~q.seen & ~lane_comma_i & ~lane_align_k_i)) |=> !sync_n_o);

    // R9: start indication is a single pulse
    p_ilas_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ilas_start_o |=> !ilas_start_o);

    // R10: misalignment after release re-requests sync
    p_misalign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_n_o && misalign_i) |=> !sync_n_o);

    // R13: restart suppresses the start indication
    p_restart_prio_r13: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ilas_start_o);
endmodule

// File: rtl/cgs_sync_top.sv
module cgs_sync_top
    import cgs_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int CGS_MIN    = 4,
    parameter int ERR_WIN    = 4,
    parameter int ERR_THRESH = 3,
    parameter int FRAME_LEN  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LANES-1:0]   lane_en_i,
    input  logic [8*NUM_LANES-1:0] rx_octet_i,
    input  logic [NUM_LANES-1:0]   rx_is_k_i,
    input  logic [NUM_LANES-1:0]   rx_dec_err_i,
    input  logic                   misalign_i,
    output logic                   sync_n_o,
    output logic [NUM_LANES-1:0]   lane_synced_o,
    output logic                   all_synced_o,
    output logic                   ilas_start_o
);
    logic [NUM_LANES-1:0] comma, align_k, synced;
    logic                 restart;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        cgs_lane_fsm #(
            .CGS_MIN   (CGS_MIN),
            .ERR_WIN   (ERR_WIN),
            .ERR_THRESH(ERR_THRESH)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .octet_i  (rx_octet_i[8*g +: 8]),
            .is_k_i   (rx_is_k_i[g]),
            .dec_err_i(rx_dec_err_i[g]),
            .restart_i(restart),
            .comma_o  (comma[g]),
            .align_k_o(align_k[g]),
            .synced_o (synced[g])
        );
    end

    cgs_link_ctrl #(
        .NUM_LANES(NUM_LANES),
        .FRAME_LEN(FRAME_LEN)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane_en_i     (lane_en_i),
        .lane_synced_i (synced),
        .lane_comma_i  (comma),
        .lane_align_k_i(align_k),
        .misalign_i    (misalign_i),
        .restart_o     (restart),
        .sync_n_o      (sync_n_o),
        .all_synced_o  (all_synced_o),
        .ilas_start_o  (ilas_start_o)
    );

    assign lane_synced_o = synced;

    // R1: nothing reports sync while the request is held from reset
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!sync_n_o && lane_synced_o == '0 && !ilas_start_o));
endmodule

// File: tb/cgs_sync_top_tb_top.sv
`timescale 1ns/1ps
module cgs_sync_top_tb_top;
    localparam int NL  = 4;
    localparam int CGS = 4;
    localparam int WIN = 4;
    localparam int THR = 3;
    localparam int FR  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NL-1:0]   en;
    logic [8*NL-1:0] oct;
    logic [NL-1:0]   k, e;
    logic            mis;
    logic            sync_n, all_synced, ilas_start;
    logic [NL-1:0]   lane_synced;

    cgs_sync_top #(.NUM_LANES(NL), .CGS_MIN(CGS), .ERR_WIN(WIN),
                   .ERR_THRESH(THR), .FRAME_LEN(FR)) dut_i (
        .clk(clk), .rst_n(rst_n), .lane_en_i(en), .rx_octet_i(oct),
        .rx_is_k_i(k), .rx_dec_err_i(e), .misalign_i(mis),
        .sync_n_o(sync_n), .lane_synced_o(lane_synced),
        .all_synced_o(all_synced), .ilas_start_o(ilas_start));

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    int           ms[NL];
    int           mc[NL];
    logic [WIN-2:0] mh[NL];
    bit           mseen[NL];
    int           mctl = 0;
    int           mhold = 0;
    bit           milas = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(int i, logic [7:0] o, logic kk, logic ee);
        oct[8*i +: 8] = o;
        k[i] = kk;
        e[i] = ee;
    endtask

    task automatic all_comma();
        for (int i = 0; i < NL; i++) put(i, 8'hBC, 1'b1, 1'b0);
    endtask

    task automatic all_data();
        for (int i = 0; i < NL; i++) put(i, 8'h5A, 1'b0, 1'b0);
    endtask

    task automatic model_step();
        bit comma[NL];
        bit ak[NL];
        bit nseen[NL];
        bit all_ok = 1'b1;
        bit lost = 1'b0;
        bit bad = 1'b0;
        bit restart = 1'b0;
        bit allseen = 1'b1;
        bit nilas = 1'b0;
        int nctl = mctl;
        int nhold = 0;
        for (int i = 0; i < NL; i++) begin
            comma[i] = k[i] && oct[8*i +: 8] == 8'hBC && !e[i];
            ak[i]    = k[i] && oct[8*i +: 8] == 8'h1C && !e[i];
            nseen[i] = mseen[i];
            if (en[i] && ms[i] != 2) begin all_ok = 1'b0; lost = 1'b1; end
        end
        if (mctl == 0) begin
            nhold = (mhold == FR) ? FR : mhold + 1;
            if (mhold == FR && all_ok) begin nctl = 1; nhold = 0; end
        end else if (mctl == 1) begin
            for (int i = 0; i < NL; i++)
                if (en[i] && !mseen[i]) begin
                    if (ak[i]) nseen[i] = 1'b1;
                    else if (!comma[i]) bad = 1'b1;
                end
            restart = lost || mis || bad;
            for (int i = 0; i < NL; i++) if (en[i] && !nseen[i]) allseen = 1'b0;
            if (allseen) begin nctl = 2; nilas = 1'b1; end
        end else begin
            restart = lost || mis;
        end
        if (restart) begin
            nctl = 0; nhold = 0; nilas = 1'b0;
            for (int i = 0; i < NL; i++) nseen[i] = 1'b0;
        end
        for (int i = 0; i < NL; i++) begin
            if (restart) begin
                ms[i] = 0; mc[i] = 0; mh[i] = '0;
            end else if (ms[i] == 0) begin
                if (comma[i]) begin ms[i] = 1; mc[i] = 1; end
            end else if (ms[i] == 1) begin
                if (!comma[i]) begin ms[i] = 0; mc[i] = 0; end
                else if (mc[i] == CGS - 1) begin ms[i] = 2; mc[i] = 0; mh[i] = '0; end
                else mc[i]++;
            end else begin
                logic [WIN-1:0] w;
                w = {mh[i], e[i]};
                if ($countones(w) >= THR) begin ms[i] = 0; mh[i] = '0; end
                else mh[i] = w[WIN-2:0];
            end
            mseen[i] = nseen[i];
        end
        mctl = nctl; mhold = nhold; milas = nilas;
    endtask

    task automatic compare();
        bit exp_all = 1'b1;
        for (int i = 0; i < NL; i++) begin
            chk(lane_synced[i] == (ms[i] == 2), "R2", $sformatf("model lane%0d synced", i),
                int'(lane_synced[i]), int'(ms[i] == 2));
            if (en[i] && ms[i] != 2) exp_all = 1'b0;
        end
        chk(sync_n == (mctl != 0), "R5", "model sync_n", int'(sync_n), int'(mctl != 0));
        chk(all_synced == exp_all, "R12", "model all_synced", int'(all_synced), int'(exp_all));
        chk(ilas_start == milas, "R9", "model ilas_start", int'(ilas_start), int'(milas));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic bring_up();
        for (int n = 0; n < 40 && !(sync_n && mctl != 0); n++) begin
            all_comma();
            tick();
        end
        chk(sync_n == 1'b1, "R5", "link released after commas", int'(sync_n), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NL; i++) begin ms[i] = 0; mc[i] = 0; mh[i] = '0; mseen[i] = 1'b0; end
        en = 4'b0111; mis = 1'b0; oct = '0; k = '0; e = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sync_n == 1'b0, "R1", "sync_n in reset", int'(sync_n), 0);
        chk(lane_synced == '0, "R1", "lane_synced in reset", int'(lane_synced), 0);
        chk(ilas_start == 1'b0, "R1", "ilas_start in reset", int'(ilas_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R2/R3: three commas, lane1 broken on the fourth character
        for (int n = 0; n < 3; n++) begin
            all_comma(); put(3, 8'h00, 1'b0, 1'b0); tick();
        end
        chk(lane_synced[0] == 1'b0, "R2", "no sync after three commas", int'(lane_synced[0]), 0);
        all_comma(); put(3, 8'h00, 1'b0, 1'b0); put(1, 8'h47, 1'b0, 1'b0); tick();
        chk(lane_synced[0] == 1'b1, "R2", "sync after four commas", int'(lane_synced[0]), 1);
        chk(lane_synced[1] == 1'b0, "R3", "broken run not synced", int'(lane_synced[1]), 0);
        for (int n = 0; n < 4; n++) begin
            all_comma(); put(3, 8'h00, 1'b0, 1'b0); tick();
        end
        chk(lane_synced[1] == 1'b1 && sync_n == 1'b0, "R5", "lane1 synced, request still low",
            int'(sync_n), 0);
        all_comma(); put(3, 8'h00, 1'b0, 1'b0); tick();
        chk(sync_n == 1'b1, "R5", "release after last lane synced", int'(sync_n), 1);
        chk(lane_synced[3] == 1'b0 && all_synced == 1'b1, "R12", "disabled lane ignored",
            int'(all_synced), 1);

        // R9: skewed alignment starts
        all_comma(); put(3, 8'h00, 1'b0, 1'b0); put(0, 8'h1C, 1'b1, 1'b0); tick();
        chk(ilas_start == 1'b0, "R9", "no pulse with lanes pending", int'(ilas_start), 0);
        all_data(); put(1, 8'h1C, 1'b1, 1'b0); put(2, 8'h1C, 1'b1, 1'b0); tick();
        chk(ilas_start == 1'b1, "R9", "pulse after last lane start", int'(ilas_start), 1);
        all_data(); tick();
        chk(ilas_start == 1'b0, "R9", "pulse lasts one cycle", int'(ilas_start), 0);

        // R4/R7: error windows on lane 2
        begin
            bit pat[7] = '{1, 0, 0, 1, 0, 1, 1};
            for (int n = 0; n < 6; n++) begin
                all_data(); e[2] = pat[n]; tick();
            end
            chk(lane_synced[2] == 1'b1, "R4", "two errors per window keep sync", int'(lane_synced[2]), 1);
            all_data(); e[2] = pat[6]; tick();
            chk(lane_synced[2] == 1'b0 && sync_n == 1'b1, "R4", "third error drops lane",
                int'(lane_synced[2]), 0);
            all_data(); tick();
            chk(sync_n == 1'b0, "R7", "lost lane re-requests sync", int'(sync_n), 0);
        end

        // R8: bad exit from the comma stream
        bring_up();
        all_comma(); put(1, 8'h55, 1'b0, 1'b0); tick();
        chk(sync_n == 1'b0, "R8", "bad transition restarts", int'(sync_n), 0);
        for (int n = 0; n < FR; n++) begin
            all_comma(); tick();
            chk(sync_n == 1'b0, "R6", "request held low", int'(sync_n), 0);
        end

        // R10/R11: misalignment in data phase
        bring_up();
        all_comma(); for (int i = 0; i < NL; i++) put(i, 8'h1C, 1'b1, 1'b0); tick();
        chk(ilas_start == 1'b1, "R9", "aligned start pulse", int'(ilas_start), 1);
        all_data(); tick();
        all_data(); mis = 1'b1; tick(); mis = 1'b0;
        chk(sync_n == 1'b0, "R10", "misalignment restarts", int'(sync_n), 0);
        chk(lane_synced == '0, "R11", "lanes cleared on restart", int'(lane_synced), 0);

        // R13: final start character and misalignment together
        bring_up();
        all_comma(); put(0, 8'h1C, 1'b1, 1'b0); put(1, 8'h1C, 1'b1, 1'b0); tick();
        all_data(); put(2, 8'h1C, 1'b1, 1'b0); mis = 1'b1; tick(); mis = 1'b0;
        chk(ilas_start == 1'b0, "R13", "restart suppresses pulse", int'(ilas_start), 0);
        chk(sync_n == 1'b0, "R13", "restart wins", int'(sync_n), 0);

        // R12: single enabled lane, others silent
        en = 4'b1000;
        bring_up();
        all_data(); put(3, 8'h1C, 1'b1, 1'b0); tick();
        chk(ilas_start == 1'b1, "R12", "pulse with one enabled lane", int'(ilas_start), 1);
        all_data(); tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule